// File: doc/BRIEF.md
# Prioritized Nestable Interrupt Controller

This block sits beside a small CPU core. It collects 44 maskable interrupt sources and 4 non-maskable trap sources, and it decides which one the core takes next. Each maskable source has a sticky request flag, an enable bit and a 3-bit priority. These are held in registers that software reaches through a simple word-wide read/write port. On every cycle the block finds the best eligible request and compares it with the current 4-bit CPU priority level. The result of that comparison is registered. When a request wins, the block sends a one-cycle take strobe with the vector number and the table-select bit.

The block keeps the CPU priority level itself. Taking an interrupt pushes the old level onto an internal stack and raises the level to the priority of the taken source. A return-from-interrupt pulse restores the saved level. Three global modes shape arbitration:
- a no-nesting mode, which stops maskable nesting and freezes software writes to the level;
- a timed disable window, counted down by instruction-retire pulses, which passes only priority-7 requests and traps;
- an alternate vector table select, which travels with every take.

Top module: `irqc_top`

Register map (16-bit words, `reg_addr`):
- 0, 1, 2: request flags for sources 0-15, 16-31 and 32-43, one bit per source. Writing 1 to a bit clears it.
- 3, 4, 5: enable bits, with the same bit layout as the flags.
- 6: control. Bit 0 is no-nesting. Bit 1 is alternate-table select. Bit 2 is window-active, which is read-only. Bits 11:8 are the trap flags, and writing 1 to one of them clears it.
- 7: CPU priority level in bits 3:0.
- 8: disable-window count. Writing loads it; reading returns it.
- 16 to 26: priorities. Source i sits in word 16+i/4, bits 4*(i%4)+2 : 4*(i%4).

Any other address reads 0.

## Requirements
- R1: A source event sets its flag on the next clock whether or not the source is enabled. Writing a 1 to the flag bit clears it. An event in the same cycle as a clearing write wins. Taking the interrupt leaves the flag set.
- R2: A source whose enable bit is 0, or whose priority is 0, is never taken.
- R3: A source is taken only when its priority is strictly greater than the CPU level. The take strobe is high for one cycle, one clock after the flags, enables and priorities allow the request. Trap k has vector k, and source i has vector 4+i.
- R4: Among eligible requests the highest level wins. On equal levels the lower vector number wins.
- R5: A take pushes the old CPU level and sets the level to the level of the taken request. An `rti` pulse pops the saved level, or does nothing when the stack is empty. No take is decided in a cycle where `rti` is high. A take has precedence over a level write.
- R6: With no-nesting set, no maskable source is taken while any interrupt is in service. Writes to the level register are ignored in this mode.
- R7: Writing address 8 loads the window count. Each `insn_retire` pulse decrements a nonzero count, and the count stops at 0; a load in the same cycle has precedence. While the count is nonzero, control bit 2 reads 1 and only priority-7 sources and traps can be taken.
- R8: `take_alt` carries the alternate-table bit as it was when the take was decided.
- R9: Trap flags are always enabled. Trap k has level 11-k. Traps are not blocked by the window or by no-nesting.
- R10: Every register reads back the value the map above defines.
- R11: After reset all flags, enables, priorities, control bits, the window count and the level are 0, and `take` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 44 | Per-source event pulses |
| trap_evt | input | 4 | Per-trap event pulses |
| insn_retire | input | 1 | Instruction retired; steps the disable window |
| rti | input | 1 | Return from interrupt; pops the saved level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| take | output | 1 | One-cycle interrupt-take strobe |
| take_vec | output | 6 | Vector number of the taken request |
| take_alt | output | 1 | Alternate vector table selected for this take |
| cpu_lvl | output | 4 | Current CPU priority level |

## Verification
The hardest state to reach is a deep nest in which the stack, the no-nesting freeze and the disable window all interact with requests that are still pending. Taken flags stay set, so a careless return re-takes the same source.

The bench drives each scenario from a fresh reset. It first sets up enables and priorities through the register port, then fires events in chosen cycles, and clears flags by write before each return so that the restored level is what it observes. A long random phase then mixes events, register writes, returns and retire pulses, and checks every cycle against a behavioural model with an explicit level stack.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC     = 44;
    localparam int NUM_TRAP    = 4;
    localparam int PRIO_W      = 3;
    localparam int LVL_W       = 4;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 5;
    localparam int WIN_W       = 16;
    localparam int STACK_DEPTH = 12;

    localparam int VEC_W         = $clog2(NUM_SRC + NUM_TRAP);
    localparam int NUM_WORDS     = (NUM_SRC + DATA_W - 1) / DATA_W;
    localparam int PRIO_PER_WORD = DATA_W / LVL_W;
    localparam int PRIO_WORDS    = (NUM_SRC + PRIO_PER_WORD - 1) / PRIO_PER_WORD;
    localparam int DEPTH_W       = $clog2(STACK_DEPTH + 1);
    localparam int IDX_W         = $clog2(STACK_DEPTH);

    // register word addresses
    localparam int A_FLAG_BASE = 0;
    localparam int A_EN_BASE   = A_FLAG_BASE + NUM_WORDS;
    localparam int A_CTRL      = A_EN_BASE + NUM_WORDS;
    localparam int A_LVL       = A_CTRL + 1;
    localparam int A_WIN       = A_LVL + 1;
    localparam int A_PRIO_BASE = 16;

    // control word bit positions
    localparam int C_NONEST   = 0;
    localparam int C_ALT      = 1;
    localparam int C_WINACT   = 2;
    localparam int C_TRAP_LSB = 8;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    localparam prio_t TOP_PRIO = '1;

    typedef struct packed {
        logic nonest;
        logic alt;
    } ctrl_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
        lvl_t lvl;
    } pick_t;

    // traps sit above every maskable level; lower index is higher level
    function automatic lvl_t trap_level(input int k);
        return lvl_t'((1 << PRIO_W) + NUM_TRAP - 1 - k);
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC-1:0]          src_evt,
    input  logic [NUM_TRAP-1:0]         trap_evt,
    input  logic                        insn_retire,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  lvl_t                        cur_lvl,
    output logic [NUM_SRC-1:0]          flag_q,
    output logic [NUM_SRC-1:0]          en_q,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q,
    output logic [NUM_TRAP-1:0]         trap_q,
    output ctrl_t                       ctrl_q,
    output logic                        win_active,
    output logic                        lvl_we,
    output lvl_t                        lvl_wdata
);

    logic [WIN_W-1:0]                      win_q;
    logic [NUM_WORDS*DATA_W-1:0]           flag_pad;
    logic [NUM_WORDS*DATA_W-1:0]           en_pad;
    logic [PRIO_WORDS*PRIO_PER_WORD*LVL_W-1:0] prio_pad;
    logic                                  ctrl_hit;
    logic                                  win_load;

    assign ctrl_hit   = reg_we && (reg_addr == ADDR_W'(A_CTRL));
    assign win_load   = reg_we && (reg_addr == ADDR_W'(A_WIN));
    assign lvl_we     = reg_we && (reg_addr == ADDR_W'(A_LVL));
    assign lvl_wdata  = reg_wdata[LVL_W-1:0];
    assign win_active = (win_q != '0);

    // per-source state
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int W  = i / DATA_W;
        localparam int B  = i % DATA_W;
        localparam int PW = i / PRIO_PER_WORD;
        localparam int PB = (i % PRIO_PER_WORD) * LVL_W;
        logic  f_q;
        logic  e_q;
        prio_t p_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                f_q <= 1'b0;
                e_q <= 1'b0;
                p_q <= '0;
            end else begin
                if (src_evt[i])
                    f_q <= 1'b1;
                else if (reg_we && reg_addr == ADDR_W'(A_FLAG_BASE + W) && reg_wdata[B])
                    f_q <= 1'b0;
                if (reg_we && reg_addr == ADDR_W'(A_EN_BASE + W))
                    e_q <= reg_wdata[B];
                if (reg_we && reg_addr == ADDR_W'(A_PRIO_BASE + PW))
                    p_q <= reg_wdata[PB +: PRIO_W];
            end
        end

        assign flag_q[i] = f_q;
        assign en_q[i]   = e_q;
        assign prio_q[i] = p_q;
        assign prio_pad[i*LVL_W +: LVL_W] = {{(LVL_W-PRIO_W){1'b0}}, p_q};
    end

    for (genvar j = NUM_SRC; j < PRIO_WORDS*PRIO_PER_WORD; j++) begin : g_prio_pad
        assign prio_pad[j*LVL_W +: LVL_W] = '0;
    end

    assign flag_pad = (NUM_WORDS*DATA_W)'(flag_q);
    assign en_pad   = (NUM_WORDS*DATA_W)'(en_q);

    // traps, control and window
    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= '0;
            ctrl_q <= '0;
            win_q  <= '0;
        end else begin
            for (int k = 0; k < NUM_TRAP; k++) begin
                if (trap_evt[k])
                    trap_q[k] <= 1'b1;
                else if (ctrl_hit && reg_wdata[C_TRAP_LSB + k])
                    trap_q[k] <= 1'b0;
            end
            if (ctrl_hit) begin
                ctrl_q.nonest <= reg_wdata[C_NONEST];
                ctrl_q.alt    <= reg_wdata[C_ALT];
            end
            if (win_load)
                win_q <= reg_wdata[WIN_W-1:0];
            else if (insn_retire && win_active)
                win_q <= win_q - 1'b1;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_addr == ADDR_W'(A_FLAG_BASE + w)) reg_rdata = flag_pad[w*DATA_W +: DATA_W];
            if (reg_addr == ADDR_W'(A_EN_BASE + w))   reg_rdata = en_pad[w*DATA_W +: DATA_W];
        end
        for (int w = 0; w < PRIO_WORDS; w++) begin
            if (reg_addr == ADDR_W'(A_PRIO_BASE + w))
                reg_rdata = prio_pad[w*DATA_W +: DATA_W];
        end
        if (reg_addr == ADDR_W'(A_CTRL)) begin
            reg_rdata[C_NONEST] = ctrl_q.nonest;
            reg_rdata[C_ALT]    = ctrl_q.alt;
            reg_rdata[C_WINACT] = win_active;
            reg_rdata[C_TRAP_LSB +: NUM_TRAP] = trap_q;
        end
        if (reg_addr == ADDR_W'(A_LVL)) reg_rdata = DATA_W'(cur_lvl);
        if (reg_addr == ADDR_W'(A_WIN)) reg_rdata = DATA_W'(win_q);
    end

    // R1: without a register write no flag ever drops
    p_flag_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R7: a retire pulse steps a nonzero window down by one
    p_win_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!win_load && insn_retire && win_q != '0) |=> (win_q == $past(win_q) - 1'b1));

    // R7: an empty window stays empty until loaded
    p_win_floor_r7: assert property (@(posedge clk) disable iff (rst)
        (!win_load && win_q == '0) |=> (win_q == '0));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SRC-1:0]             flag_q,
    input  logic [NUM_SRC-1:0]             en_q,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q,
    input  logic [NUM_TRAP-1:0]            trap_q,
    input  lvl_t                           cur_lvl,
    input  logic                           nest_block,
    input  logic                           win_active,
    input  logic                           rti,
    output pick_t                          pick
);

    // ascending vector scan with strict compare: ties keep the lower vector
    always_comb begin
        lvl_t best_lvl;
        pick     = '0;
        best_lvl = cur_lvl;
        for (int k = 0; k < NUM_TRAP; k++) begin
            if (trap_q[k] && trap_level(k) > best_lvl) begin
                best_lvl   = trap_level(k);
                pick.valid = 1'b1;
                pick.vec   = vec_t'(k);
                pick.lvl   = trap_level(k);
            end
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (flag_q[i] && en_q[i] && prio_q[i] != '0 && !nest_block &&
                (!win_active || prio_q[i] == TOP_PRIO) &&
                lvl_t'(prio_q[i]) > best_lvl) begin
                best_lvl   = lvl_t'(prio_q[i]);
                pick.valid = 1'b1;
                pick.vec   = vec_t'(NUM_TRAP + i);
                pick.lvl   = lvl_t'(prio_q[i]);
            end
        end
        if (rti) pick.valid = 1'b0;
    end

    // R3: a chosen request always lies strictly above the CPU level
    p_above_level_r3: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> (pick.lvl > cur_lvl));

    // R7: under the window only top-priority sources or traps get through
    p_window_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (pick.valid && win_active) |-> (pick.lvl >= lvl_t'(TOP_PRIO)));

    // R6: while nesting is blocked only traps can be chosen
    p_nonest_trap_only_r6: assert property (@(posedge clk) disable iff (rst)
        (pick.valid && nest_block) |-> (pick.vec < vec_t'(NUM_TRAP)));

    // R5: nothing is chosen in a return cycle
    p_rti_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        rti |-> !pick.valid);

endmodule

// File: rtl/irqc_level_stack.sv
module irqc_level_stack
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pick_t pick,
    input  logic  rti,
    input  logic  lvl_we,
    input  lvl_t  lvl_wdata,
    input  ctrl_t ctrl_q,
    output lvl_t  cur_lvl,
    output logic  in_service,
    output logic  take,
    output vec_t  take_vec,
    output logic  take_alt
);

    lvl_t               stk_q [STACK_DEPTH];
    logic [DEPTH_W-1:0] depth_q;
    logic [DEPTH_W-1:0] top_pos;
    logic [IDX_W-1:0]   push_idx;
    logic [IDX_W-1:0]   pop_idx;

    assign top_pos    = depth_q - 1'b1;
    assign push_idx   = depth_q[IDX_W-1:0];
    assign pop_idx    = top_pos[IDX_W-1:0];
    assign in_service = (depth_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_lvl  <= '0;
            depth_q  <= '0;
            take     <= 1'b0;
            take_vec <= '0;
            take_alt <= 1'b0;
            for (int j = 0; j < STACK_DEPTH; j++) stk_q[j] <= '0;
        end else begin
            take <= pick.valid;
            if (pick.valid) begin
                take_vec <= pick.vec;
                take_alt <= ctrl_q.alt;
                if (depth_q < DEPTH_W'(STACK_DEPTH)) begin
                    stk_q[push_idx] <= cur_lvl;
                    depth_q         <= depth_q + 1'b1;
                end
                cur_lvl <= pick.lvl;
            end else if (rti) begin
                if (in_service) begin
                    cur_lvl <= stk_q[pop_idx];
                    depth_q <= top_pos;
                end
            end else if (lvl_we && !ctrl_q.nonest) begin
                cur_lvl <= lvl_wdata;
            end
        end
    end

    // R5: a take always leaves the CPU level higher than before
    p_take_raises_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> (cur_lvl > $past(cur_lvl)));

    // R5: a return with something in service pops exactly one entry
    p_rti_pops_r5: assert property (@(posedge clk) disable iff (rst)
        (rti && in_service) |=> (depth_q == $past(depth_q) - 1'b1));

    // R6: level writes are ignored in no-nesting mode
    p_level_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (lvl_we && ctrl_q.nonest && !pick.valid && !rti) |=> (cur_lvl == $past(cur_lvl)));

    // R5: the stack never holds more entries than it has
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        depth_q <= DEPTH_W'(STACK_DEPTH));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_evt,
    input  logic [NUM_TRAP-1:0]  trap_evt,
    input  logic                 insn_retire,
    input  logic                 rti,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 take,
    output logic [VEC_W-1:0]     take_vec,
    output logic                 take_alt,
    output logic [LVL_W-1:0]     cpu_lvl
);

    logic [NUM_SRC-1:0]             flag_q;
    logic [NUM_SRC-1:0]             en_q;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_TRAP-1:0]            trap_q;
    ctrl_t                          ctrl_q;
    logic                           win_active;
    logic                           lvl_we;
    lvl_t                           lvl_wdata;
    lvl_t                           cur_lvl;
    logic                           in_service;
    pick_t                          pick;

    irqc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .src_evt    (src_evt),
        .trap_evt   (trap_evt),
        .insn_retire(insn_retire),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cur_lvl    (cur_lvl),
        .flag_q     (flag_q),
        .en_q       (en_q),
        .prio_q     (prio_q),
        .trap_q     (trap_q),
        .ctrl_q     (ctrl_q),
        .win_active (win_active),
        .lvl_we     (lvl_we),
        .lvl_wdata  (lvl_wdata)
    );

    irqc_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .flag_q     (flag_q),
        .en_q       (en_q),
        .prio_q     (prio_q),
        .trap_q     (trap_q),
        .cur_lvl    (cur_lvl),
        .nest_block (ctrl_q.nonest && in_service),
        .win_active (win_active),
        .rti        (rti),
        .pick       (pick)
    );

    irqc_level_stack u_lvl (
        .clk        (clk),
        .rst        (rst),
        .pick       (pick),
        .rti        (rti),
        .lvl_we     (lvl_we),
        .lvl_wdata  (lvl_wdata),
        .ctrl_q     (ctrl_q),
        .cur_lvl    (cur_lvl),
        .in_service (in_service),
        .take       (take),
        .take_vec   (take_vec),
        .take_alt   (take_alt)
    );

    assign cpu_lvl = cur_lvl;

endmodule

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [43:0] d_evt = '0;
    logic [3:0]  d_trap = '0;
    logic        d_ret = 1'b0;
    logic        d_rti = 1'b0;
    logic        d_we = 1'b0;
    logic [4:0]  d_addr = '0;
    logic [15:0] d_wdata = '0;
    logic [15:0] rdata;
    logic        take;
    logic [5:0]  take_vec;
    logic        take_alt;
    logic [3:0]  cpu_lvl;

    always #2.5 clk = ~clk;

    irqc_top dut_i (
        .clk(clk), .rst(rst), .src_evt(d_evt), .trap_evt(d_trap),
        .insn_retire(d_ret), .rti(d_rti), .reg_we(d_we), .reg_addr(d_addr),
        .reg_wdata(d_wdata), .reg_rdata(rdata), .take(take),
        .take_vec(take_vec), .take_alt(take_alt), .cpu_lvl(cpu_lvl)
    );

    int errors = 0;
    int checks = 0;
    string cur_tag = "R11";

    // behavioural model
    logic [43:0] m_flag, m_en;
    logic [2:0]  m_prio [44];
    logic [3:0]  m_trap;
    bit          m_nonest, m_alt;
    int          m_lvl, m_win;
    int          m_stk [$];
    bit          e_take;
    int          e_vec;
    bit          e_alt;
    int          seen_vec, seen_cnt;
    bit          seen_alt;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_flag = '0; m_en = '0; m_trap = '0;
        foreach (m_prio[i]) m_prio[i] = '0;
        m_nonest = 0; m_alt = 0; m_lvl = 0; m_win = 0;
        m_stk.delete();
        e_take = 0; e_vec = 0; e_alt = 0;
    endtask

    function automatic logic [15:0] model_read(input int a);
        logic [15:0] r = '0;
        if (a <= 2) for (int b = 0; b < 16; b++) if (a*16+b < 44) r[b] = m_flag[a*16+b];
        if (a >= 3 && a <= 5) for (int b = 0; b < 16; b++) if ((a-3)*16+b < 44) r[b] = m_en[(a-3)*16+b];
        if (a == 6) begin r[0] = m_nonest; r[1] = m_alt; r[2] = (m_win != 0); r[11:8] = m_trap; end
        if (a == 7) r = 16'(m_lvl);
        if (a == 8) r = 16'(m_win);
        if (a >= 16 && a <= 26) for (int s = 0; s < 4; s++) r[s*4 +: 3] = m_prio[(a-16)*4+s];
        return r;
    endfunction

    task automatic model_step();
        int best = m_lvl;
        int bv = -1;
        for (int k = 0; k < 4; k++)
            if (m_trap[k] && (11-k) > best) begin best = 11-k; bv = k; end
        for (int i = 0; i < 44; i++)
            if (m_flag[i] && m_en[i] && m_prio[i] != 0 && !(m_nonest && m_stk.size() > 0) &&
                !(m_win != 0 && m_prio[i] != 7) && int'(m_prio[i]) > best) begin
                best = int'(m_prio[i]); bv = 4 + i;
            end
        if (d_rti) bv = -1;
        e_take = (bv >= 0);
        if (e_take) begin e_vec = bv; e_alt = m_alt; end
        if (e_take) begin
            if (m_stk.size() < 12) m_stk.push_back(m_lvl);
            m_lvl = best;
        end else if (d_rti) begin
            if (m_stk.size() > 0) m_lvl = m_stk.pop_back();
        end else if (d_we && d_addr == 7 && !m_nonest) m_lvl = int'(d_wdata[3:0]);
        for (int i = 0; i < 44; i++) begin
            if (d_evt[i]) m_flag[i] = 1;
            else if (d_we && d_addr == 5'(i/16) && d_wdata[i%16]) m_flag[i] = 0;
            if (d_we && d_addr == 5'(3 + i/16)) m_en[i] = d_wdata[i%16];
            if (d_we && d_addr == 5'(16 + i/4)) m_prio[i] = d_wdata[(i%4)*4 +: 3];
        end
        for (int k = 0; k < 4; k++) begin
            if (d_trap[k]) m_trap[k] = 1;
            else if (d_we && d_addr == 6 && d_wdata[8+k]) m_trap[k] = 0;
        end
        if (d_we && d_addr == 6) begin m_nonest = d_wdata[0]; m_alt = d_wdata[1]; end
        if (d_we && d_addr == 8) m_win = int'(d_wdata);
        else if (d_ret && m_win > 0) m_win--;
    endtask

    task automatic compare();
        chk(take == e_take, {cur_tag, " take R3"}, take, e_take);
        if (e_take) begin
            chk(take_vec == 6'(e_vec), {cur_tag, " vector R4"}, take_vec, e_vec);
            chk(take_alt == e_alt, {cur_tag, " alt R8"}, take_alt, e_alt);
        end
        chk(cpu_lvl == 4'(m_lvl), {cur_tag, " level R5"}, cpu_lvl, m_lvl);
        if (take) begin seen_vec = take_vec; seen_alt = take_alt; seen_cnt++; end
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        d_evt = '0; d_trap = '0; d_we = 0; d_ret = 0; d_rti = 0;
    endtask

    task automatic wr(input int a, input int v);
        d_we = 1; d_addr = 5'(a); d_wdata = 16'(v); step();
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    task automatic rd_chk(input int a, input string tag);
        d_we = 0; d_addr = 5'(a);
        #1;
        chk(rdata == model_read(a), tag, rdata, model_read(a));
    endtask

    task automatic do_reset();
        rst = 1;
        d_evt = '0; d_trap = '0; d_we = 0; d_ret = 0; d_rti = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
        seen_cnt = 0; seen_vec = -1; seen_alt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R3 watchdog expired act=1 exp=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11: reset state
        do_reset();
        cur_tag = "R11";
        chk(take == 0, "R11 take low", take, 0);
        chk(cpu_lvl == 0, "R11 level zero", cpu_lvl, 0);
        for (int a = 0; a < 27; a++) begin
            d_addr = 5'(a); #1;
            chk(rdata == 16'h0, "R11 register zero", rdata, 0);
        end
        idle(2);

        // R1: flag sets while disabled, clears by write-one, event wins
        do_reset(); cur_tag = "R1";
        d_evt[5] = 1; step();
        rd_chk(0, "R1 flag set");
        chk(rdata[5] == 1, "R1 flag bit", rdata[5], 1);
        idle(3);
        chk(seen_cnt == 0, "R1 no take while disabled", seen_cnt, 0);
        wr(0, 1 << 5);
        rd_chk(0, "R1 flag clear");
        chk(rdata[5] == 0, "R1 cleared bit", rdata[5], 0);
        d_evt[5] = 1; wr(0, 1 << 5);
        rd_chk(0, "R1 event beats clear");
        chk(rdata[5] == 1, "R1 event beats clear bit", rdata[5], 1);

        // R2: enabled but priority zero is never taken
        cur_tag = "R2";
        wr(3, 1 << 5);
        idle(3);
        chk(seen_cnt == 0, "R2 priority zero", seen_cnt, 0);

        // R3: priority 3 above level 0 is taken; flag stays
        cur_tag = "R3";
        wr(17, 3 << 4);
        idle(3);
        chk(seen_cnt == 1 && seen_vec == 9, "R3 vector of source 5", seen_vec, 9);
        chk(cpu_lvl == 3, "R3 level raised", cpu_lvl, 3);
        rd_chk(0, "R1 flag kept after take");
        chk(rdata[5] == 1, "R1 flag kept bit", rdata[5], 1);
        // equal level blocks: pop to 0 then write level 3 first
        wr(7, 3);              // take has been made; level write allowed (nonest off)
        wr(0, 1 << 5);
        d_rti = 1; step();
        d_evt[5] = 1; wr(7, 3);
        seen_cnt = 0;
        idle(3);
        chk(seen_cnt == 0, "R3 equal level not taken", seen_cnt, 0);
        wr(7, 2);
        idle(3);
        chk(seen_cnt == 1, "R3 taken once above level", seen_cnt, 1);

        // R4: highest wins, then tie by lower vector
        do_reset(); cur_tag = "R4";
        wr(3, (1 << 10)); wr(4, (1 << 4) | (1 << 14));
        wr(18, 5 << 8); wr(21, 5); wr(23, 6 << 8);
        d_evt[10] = 1; d_evt[20] = 1; d_evt[30] = 1; step();
        idle(2);
        chk(seen_vec == 34, "R4 highest priority first", seen_vec, 34);
        wr(1, 1 << 14);
        d_rti = 1; step();
        idle(2);
        chk(seen_vec == 14, "R4 tie lower vector", seen_vec, 14);

        // R5: nesting and pop
        do_reset(); cur_tag = "R5";
        wr(3, 6); wr(16, (2 << 4) | (5 << 8));
        d_evt[1] = 1; step(); idle(2);
        chk(cpu_lvl == 2, "R5 first level", cpu_lvl, 2);
        d_evt[2] = 1; step(); idle(2);
        chk(cpu_lvl == 5 && seen_vec == 6, "R5 nested level", cpu_lvl, 5);
        wr(0, 1 << 2);
        d_rti = 1; step();
        chk(cpu_lvl == 2, "R5 popped level", cpu_lvl, 2);
        idle(2);

        // R6: no-nesting blocks and freezes the level
        do_reset(); cur_tag = "R6";
        wr(6, 1); wr(3, 1 << 5); wr(17, 3 << 4); wr(4, 1 << 14); wr(23, 6 << 8);
        d_evt[5] = 1; step(); idle(2);
        chk(seen_vec == 9, "R6 first take", seen_vec, 9);
        d_evt[30] = 1; step(); idle(3);
        chk(seen_cnt == 1, "R6 higher blocked", seen_cnt, 1);
        wr(7, 5); idle(1);
        chk(cpu_lvl == 3, "R6 level write ignored", cpu_lvl, 3);
        d_rti = 1; step(); idle(2);
        chk(seen_vec == 34, "R6 pending taken after return", seen_vec, 34);

        // R7: disable window
        do_reset(); cur_tag = "R7";
        wr(4, 1 << 14); wr(23, 6 << 8); wr(5, 1 << 8); wr(26, 7);
        wr(8, 3);
        rd_chk(6, "R7 window status");
        chk(rdata[2] == 1, "R7 status bit set", rdata[2], 1);
        d_evt[30] = 1; step(); idle(2);
        chk(seen_cnt == 0, "R7 level 6 blocked", seen_cnt, 0);
        d_evt[40] = 1; step(); idle(2);
        chk(seen_vec == 44, "R7 level 7 passes", seen_vec, 44);
        wr(2, 1 << 8);
        d_rti = 1; step(); idle(2);
        chk(seen_cnt == 1, "R7 still blocked", seen_cnt, 1);
        repeat (3) begin d_ret = 1; step(); end
        d_ret = 1; step();
        rd_chk(8, "R7 count floor");
        chk(rdata == 0, "R7 count zero", rdata, 0);
        idle(2);
        chk(seen_vec == 34, "R7 taken after window", seen_vec, 34);

        // R8: alternate table
        do_reset(); cur_tag = "R8";
        wr(6, 2); wr(3, 1); wr(16, 1);
        d_evt[0] = 1; step(); idle(2);
        chk(seen_vec == 4 && seen_alt == 1, "R8 alt bit", seen_alt, 1);

        // R9: traps pass window and no-nesting
        do_reset(); cur_tag = "R9";
        wr(6, 1); wr(8, 50); wr(5, 1 << 8); wr(26, 7);
        d_evt[40] = 1; step(); idle(2);
        d_trap[2] = 1; step(); idle(1);
        chk(seen_vec == 2 && cpu_lvl == 9, "R9 trap level", cpu_lvl, 9);
        d_trap[3] = 1; step(); idle(2);
        chk(seen_vec == 2, "R9 lower trap waits", seen_vec, 2);
        rd_chk(6, "R9 trap flags readable");
        wr(6, 1 | (1 << 10));
        d_rti = 1; step(); idle(2);
        chk(seen_vec == 3, "R9 lower trap after return", seen_vec, 3);

        // R10: random mix against the model
        do_reset(); cur_tag = "R10";
        for (int c = 0; c < 4000; c++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            d_evt = r[43:0] & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            d_trap = (($urandom % 64) == 0) ? 4'($urandom) : 4'h0;
            d_ret = $urandom % 2;
            d_rti = ($urandom % 6) == 0;
            if (($urandom % 3) == 0) begin
                int sel = $urandom % 6;
                d_we = 1;
                d_wdata = 16'($urandom);
                case (sel)
                    0: d_addr = 5'($urandom % 3);
                    1: d_addr = 5'(3 + $urandom % 3);
                    2: d_addr = 5'(16 + $urandom % 11);
                    3: begin d_addr = 6; d_wdata[7:2] = '0; end
                    4: d_addr = 7;
                    default: begin d_addr = 8; d_wdata = 16'($urandom % 8); end
                endcase
            end else begin
                int a = $urandom % 32;
                rd_chk(a, "R10 readback");
            end
            if (c % 500 == 0) cur_tag = (c % 1000 == 0) ? "R10" : "R4";
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule